// File: doc/BRIEF.md
# Microstep Translator with Decay Selection

This block turns step pulses into a microstep position for a two-phase bipolar stepper motor. The position is kept as an index on a 64-point grid, with sixteen sixteenth-steps per electrical quadrant. Each rising edge of the step input moves the index by one increment in the requested direction. The resolution select decides the increment size: full, half, eighth or sixteenth step. Direction and resolution are sampled only at that edge.

From the index the block looks up a magnitude code and a polarity bit for each phase. Phase A follows the sine of the electrical angle and phase B follows the cosine. On every step the block also picks a decay-mode code for each phase by comparing the new magnitude with the old one. A phase whose current drops takes the externally decoded decay selection. A phase whose current stays level or rises is given slow decay.

A home request or an asynchronous reset puts the position at the 45° point, where both phases carry +70% current, and sets both phases to mixed decay. A one-cycle completion pulse and a home indicator are provided for a downstream fault monitor. The controller runs a three-state machine:
- HOME holds the home position while the home request is high.
- IDLE waits for a step edge.
- LOAD publishes the new phase outputs.

The transitions are:
- HOME→IDLE on home-request release.
- IDLE→LOAD on a step edge.
- LOAD→IDLE unconditionally.
- Any state→HOME on a home request.

Top module: `ustep_translator`

## Requirements
- R1: While `rst_n` is low, and on the clock edge after `home_req` is sampled high, the outputs take the home values. These are index 8, `a_mag` = `b_mag` = 180, `a_neg` = `b_neg` = 0, `a_decay` = `b_decay` = 2'b01 (mixed) and `home_flag` = 1.
- R2: A rising edge of `step_in` changes the index by the stride that `res_sel` selects: 2'b00 full = 16, 2'b01 half = 8, 2'b10 eighth = 2, 2'b11 sixteenth = 1. The edge is seen at clock edge E0. The new phase outputs appear after clock edge E0+1.
- R3: With `dir_in` = 0 the index increases (clockwise); with `dir_in` = 1 it decreases (counterclockwise). The index wraps modulo 64.
- R4: `dir_in` and `res_sel` are used only at the clock edge where the step edge is seen. Changing them at other times leaves every output unchanged.
- R5: Magnitudes use S(k) = round(255·sin(k·π/32)) for k = 0..16. For index i, take quadrant q = i/16 and offset o = i mod 16.
  - `a_mag` = S(16−o) when q is odd and S(o) otherwise.
  - `a_neg` = 1 for i in 32..63.
  - Phase B uses the same rule at index (i+16) mod 64, so `b_neg` = 1 for i in 16..47.
- R6: On a step, a phase whose new magnitude is below its previous magnitude takes its decay code from `decay_sel`, sampled at the update edge. The mapping is 00→00 (slow), 01→01 (mixed), and 10 or 11→10 (fast). A phase whose magnitude is equal or higher gets 2'b00 (slow).
- R7: While `home_req` is high, step edges are ignored and the outputs stay at the home values.
- R8: `home_flag` is 1 exactly when the published position is index 8.
- R9: `step_done` is high for one cycle per accepted step, in the cycle the new outputs appear, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset to home |
| step_in | input | 1 | Step request; rising edge advances one increment |
| dir_in | input | 1 | Direction: 0 clockwise (index up), 1 counterclockwise |
| res_sel | input | 2 | Resolution select: 00 full, 01 half, 10 eighth, 11 sixteenth |
| home_req | input | 1 | Synchronous home request (undervoltage reset or sleep exit) |
| decay_sel | input | 2 | Decoded decay choice for falling current: 00 slow, 01 mixed, 1x fast |
| a_mag | output | 8 | Phase A current magnitude code |
| a_neg | output | 1 | Phase A polarity, 1 = negative |
| a_decay | output | 2 | Phase A decay code: 00 slow, 01 mixed, 10 fast |
| b_mag | output | 8 | Phase B current magnitude code |
| b_neg | output | 1 | Phase B polarity, 1 = negative |
| b_decay | output | 2 | Phase B decay code: 00 slow, 01 mixed, 10 fast |
| step_done | output | 1 | One-cycle pulse when new phase outputs are published |
| home_flag | output | 1 | High when the position is the home index |

## Verification
The assertions check several properties on every cycle:
- the home values follow any home request;
- the phase outputs stay stable unless a step completes or a home request occurred;
- the completion pulse never lasts two cycles;
- a rising or level magnitude always gets slow decay;
- a falling magnitude follows the sampled decay selection;
- `home_flag` only appears with the 180/180 positive pattern.

Other behaviours only the bench scenarios can show:
- the exact magnitudes and polarities across all 64 indices;
- stride size and direction, including wrap below zero and above 63;
- the edge-only sampling of direction and resolution;
- rejection of step edges during a home request.

// File: rtl/ustep_pkg.sv
package ustep_pkg;

    localparam int IDX_W    = 6;
    localparam int QBITS    = IDX_W - 2;
    localparam int QTR      = 1 << QBITS;
    localparam int MAG_W    = 8;
    localparam int HOME_IDX = QTR / 2;
    localparam int NPH      = 2;

    typedef enum logic [1:0] {
        DECAY_SLOW  = 2'b00,
        DECAY_MIXED = 2'b01,
        DECAY_FAST  = 2'b10
    } decay_t;

    typedef enum logic [1:0] {
        RES_FULL      = 2'b00,
        RES_HALF      = 2'b01,
        RES_EIGHTH    = 2'b10,
        RES_SIXTEENTH = 2'b11
    } res_t;

    typedef enum logic [1:0] {
        ST_HOME = 2'b00,
        ST_IDLE = 2'b01,
        ST_LOAD = 2'b10
    } tstate_t;

    // quarter-wave sine, 255 full scale, k = 0..16
    function automatic logic [MAG_W-1:0] sine_code(input logic [QBITS:0] k);
        logic [MAG_W-1:0] v;
        case (k)
            5'd0:    v = 8'd0;
            5'd1:    v = 8'd25;
            5'd2:    v = 8'd50;
            5'd3:    v = 8'd74;
            5'd4:    v = 8'd98;
            5'd5:    v = 8'd120;
            5'd6:    v = 8'd142;
            5'd7:    v = 8'd162;
            5'd8:    v = 8'd180;
            5'd9:    v = 8'd197;
            5'd10:   v = 8'd212;
            5'd11:   v = 8'd225;
            5'd12:   v = 8'd236;
            5'd13:   v = 8'd244;
            5'd14:   v = 8'd250;
            5'd15:   v = 8'd254;
            default: v = 8'd255;
        endcase
        return v;
    endfunction

    localparam logic [MAG_W-1:0] HOME_MAG = 8'd180;

endpackage

// File: rtl/ustep_index_step.sv
module ustep_index_step
    import ustep_pkg::*;
#(
    parameter int W = IDX_W
) (
    input  logic [W-1:0] idx,
    input  logic         dir,
    input  logic [1:0]   res,
    output logic [W-1:0] idx_next
);
    localparam int Q = 1 << (W - 2);

    logic [W-1:0] stride;

    always_comb begin
        unique case (res_t'(res))
            RES_FULL:      stride = W'(Q);
            RES_HALF:      stride = W'(Q / 2);
            RES_EIGHTH:    stride = W'(Q / 8);
            RES_SIXTEENTH: stride = W'(Q / 16);
            default:       stride = W'(1);
        endcase
    end

    // modulo-2^W wrap comes from the natural width
    assign idx_next = dir ? (idx - stride) : (idx + stride);

endmodule

// File: rtl/ustep_phase_lut.sv
module ustep_phase_lut
    import ustep_pkg::*;
#(
    parameter int W      = IDX_W,
    parameter int OFFSET = 0
) (
    input  logic [W-1:0]     idx,
    output logic [MAG_W-1:0] mag,
    output logic             neg
);
    localparam int QB = W - 2;
    localparam int Q  = 1 << QB;

    logic [W-1:0]  eff;
    logic [1:0]    quad;
    logic [QB-1:0] ofs;
    logic [QB:0]   k;

    assign eff  = idx + W'(OFFSET);
    assign quad = eff[W-1 -: 2];
    assign ofs  = eff[QB-1:0];

    // odd quadrants run the quarter wave backwards
    assign k   = quad[0] ? ((QB+1)'(Q) - {1'b0, ofs}) : {1'b0, ofs};
    assign mag = sine_code(k);
    assign neg = quad[1];

endmodule

// File: rtl/ustep_decay_pick.sv
module ustep_decay_pick
    import ustep_pkg::*;
(
    input  logic [MAG_W-1:0] new_mag,
    input  logic [MAG_W-1:0] old_mag,
    input  logic [1:0]       sel,
    output decay_t           decay
);
    always_comb begin
        if (new_mag < old_mag) begin
            unique case (sel)
                2'b00:   decay = DECAY_SLOW;
                2'b01:   decay = DECAY_MIXED;
                default: decay = DECAY_FAST;
            endcase
        end else begin
            decay = DECAY_SLOW;
        end
    end
endmodule

// File: rtl/ustep_translator.sv
module ustep_translator
    import ustep_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_in,
    input  logic             dir_in,
    input  logic [1:0]       res_sel,
    input  logic             home_req,
    input  logic [1:0]       decay_sel,
    output logic [MAG_W-1:0] a_mag,
    output logic             a_neg,
    output logic [1:0]       a_decay,
    output logic [MAG_W-1:0] b_mag,
    output logic             b_neg,
    output logic [1:0]       b_decay,
    output logic             step_done,
    output logic             home_flag
);
    tstate_t          state, state_nxt;
    logic             step_q;
    logic             step_rise;
    logic [IDX_W-1:0] idx, idx_next;

    logic [MAG_W-1:0] lut_mag [NPH];
    logic             lut_neg [NPH];
    decay_t           pick    [NPH];
    logic [MAG_W-1:0] mag_r   [NPH];
    logic             neg_r   [NPH];
    decay_t           dec_r   [NPH];

    assign step_rise = step_in & ~step_q;

    ustep_index_step #(.W(IDX_W)) u_step (
        .idx      (idx),
        .dir      (dir_in),
        .res      (res_sel),
        .idx_next (idx_next)
    );

    for (genvar g = 0; g < NPH; g++) begin : g_phase
        ustep_phase_lut #(.W(IDX_W), .OFFSET(g * QTR)) u_lut (
            .idx (idx),
            .mag (lut_mag[g]),
            .neg (lut_neg[g])
        );
        ustep_decay_pick u_pick (
            .new_mag (lut_mag[g]),
            .old_mag (mag_r[g]),
            .sel     (decay_sel),
            .decay   (pick[g])
        );
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HOME;
        else        state <= state_nxt;
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_HOME: state_nxt = home_req ? ST_HOME : ST_IDLE;
            ST_IDLE: begin
                if (home_req)       state_nxt = ST_HOME;
                else if (step_rise) state_nxt = ST_LOAD;
            end
            ST_LOAD: state_nxt = home_req ? ST_HOME : ST_IDLE;
            default: state_nxt = ST_HOME;
        endcase
    end

    // position index; direction and resolution used only at the edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= 1'b0;
            idx    <= IDX_W'(HOME_IDX);
        end else begin
            step_q <= step_in;
            if (home_req)
                idx <= IDX_W'(HOME_IDX);
            else if (state == ST_IDLE && step_rise)
                idx <= idx_next;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NPH; p++) begin
                mag_r[p] <= HOME_MAG;
                neg_r[p] <= 1'b0;
                dec_r[p] <= DECAY_MIXED;
            end
            step_done <= 1'b0;
            home_flag <= 1'b1;
        end else begin
            step_done <= 1'b0;
            if (home_req) begin
                for (int p = 0; p < NPH; p++) begin
                    mag_r[p] <= HOME_MAG;
                    neg_r[p] <= 1'b0;
                    dec_r[p] <= DECAY_MIXED;
                end
                home_flag <= 1'b1;
            end else if (state == ST_LOAD) begin
                for (int p = 0; p < NPH; p++) begin
                    mag_r[p] <= lut_mag[p];
                    neg_r[p] <= lut_neg[p];
                    dec_r[p] <= pick[p];
                end
                home_flag <= (idx == IDX_W'(HOME_IDX));
                step_done <= 1'b1;
            end
        end
    end

    assign a_mag   = mag_r[0];
    assign a_neg   = neg_r[0];
    assign a_decay = dec_r[0];
    assign b_mag   = mag_r[1];
    assign b_neg   = neg_r[1];
    assign b_decay = dec_r[1];

endmodule

// File: rtl/ustep_translator_chk.sv
module ustep_translator_chk
    import ustep_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             home_req,
    input logic [1:0]       decay_sel,
    input logic [MAG_W-1:0] a_mag,
    input logic             a_neg,
    input logic [1:0]       a_decay,
    input logic [MAG_W-1:0] b_mag,
    input logic             b_neg,
    input logic [1:0]       b_decay,
    input logic             step_done,
    input logic             home_flag
);
    AST_HOME_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(home_req) |-> (a_mag == HOME_MAG && b_mag == HOME_MAG && !a_neg && !b_neg
                             && a_decay == DECAY_MIXED && b_decay == DECAY_MIXED
                             && home_flag && !step_done)); // R1

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_done && !$past(home_req)) |-> ($stable(a_mag) && $stable(b_mag)
            && $stable(a_neg) && $stable(b_neg)
            && $stable(a_decay) && $stable(b_decay))); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |=> !step_done); // R9

    AST_A_SLOW_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_done && a_mag >= $past(a_mag)) |-> a_decay == DECAY_SLOW); // R6

    AST_B_SLOW_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_done && b_mag >= $past(b_mag)) |-> b_decay == DECAY_SLOW); // R6

    AST_A_FALL_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (step_done && a_mag < $past(a_mag)) |->
            a_decay == (($past(decay_sel) == 2'b00) ? DECAY_SLOW :
                        ($past(decay_sel) == 2'b01) ? DECAY_MIXED : DECAY_FAST)); // R6

    AST_B_FALL_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (step_done && b_mag < $past(b_mag)) |->
            b_decay == (($past(decay_sel) == 2'b00) ? DECAY_SLOW :
                        ($past(decay_sel) == 2'b01) ? DECAY_MIXED : DECAY_FAST)); // R6

    AST_HOME_FLAG_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        home_flag |-> (a_mag == HOME_MAG && b_mag == HOME_MAG && !a_neg && !b_neg)); // R8

endmodule

bind ustep_translator ustep_translator_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .home_req  (home_req),
    .decay_sel (decay_sel),
    .a_mag     (a_mag),
    .a_neg     (a_neg),
    .a_decay   (a_decay),
    .b_mag     (b_mag),
    .b_neg     (b_neg),
    .b_decay   (b_decay),
    .step_done (step_done),
    .home_flag (home_flag)
);

// File: tb/ustep_translator_bench.sv
`timescale 1ns/1ps
module ustep_translator_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_in = 1'b0;
    logic       dir_in = 1'b0;
    logic [1:0] res_sel = 2'b00;
    logic       home_req = 1'b0;
    logic [1:0] decay_sel = 2'b00;
    logic [7:0] a_mag, b_mag;
    logic       a_neg, b_neg;
    logic [1:0] a_decay, b_decay;
    logic       step_done, home_flag;

    int checks = 0;
    int errors = 0;

    int m_idx, m_amag, m_bmag, m_adec, m_bdec;
    bit m_aneg, m_bneg;

    always #5 clk = ~clk;

    ustep_translator u_ustep_translator (
        .clk(clk), .rst_n(rst_n), .step_in(step_in), .dir_in(dir_in),
        .res_sel(res_sel), .home_req(home_req), .decay_sel(decay_sel),
        .a_mag(a_mag), .a_neg(a_neg), .a_decay(a_decay),
        .b_mag(b_mag), .b_neg(b_neg), .b_decay(b_decay),
        .step_done(step_done), .home_flag(home_flag)
    );

    function automatic int sinc(int k);
        return int'(255.0 * $sin(real'(k) * 3.14159265358979 / 32.0));
    endfunction

    function automatic int lut_mag(int i);
        int q = (i % 64) / 16;
        int o = i % 16;
        return (q % 2 == 1) ? sinc(16 - o) : sinc(o);
    endfunction

    function automatic bit lut_neg(int i);
        return ((i % 64) / 16) >= 2;
    endfunction

    function automatic int dec_of(int nm, int om, int ds);
        if (nm < om) return (ds == 0) ? 0 : (ds == 1) ? 1 : 2;
        return 0;
    endfunction

    function automatic int stride_of(int r);
        case (r)
            0: return 16;
            1: return 8;
            2: return 2;
            default: return 1;
        endcase
    endfunction

    task automatic chk(string req, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic model_home();
        m_idx = 8; m_amag = 180; m_bmag = 180;
        m_aneg = 0; m_bneg = 0; m_adec = 1; m_bdec = 1;
    endtask

    task automatic check_all(string req);
        chk({req, " a_mag"},     int'(a_mag),     m_amag);
        chk({req, " b_mag"},     int'(b_mag),     m_bmag);
        chk({req, " a_neg"},     int'(a_neg),     int'(m_aneg));
        chk({req, " b_neg"},     int'(b_neg),     int'(m_bneg));
        chk({req, " a_decay"},   int'(a_decay),   m_adec);
        chk({req, " b_decay"},   int'(b_decay),   m_bdec);
        chk({req, " R8 home_flag"}, int'(home_flag), (m_idx == 8) ? 1 : 0);
    endtask

    // one step: edge seen at E0, outputs published after E1
    task automatic do_step(bit d, int r, int ds, string req);
        int na, nb;
        @(negedge clk);
        dir_in = d; res_sel = 2'(r); decay_sel = 2'(ds); step_in = 1'b1;
        @(negedge clk);
        step_in = 1'b0;
        dir_in = ~d; res_sel = ~2'(r);   // R4: late changes must not matter
        @(negedge clk);
        m_idx = d ? (m_idx - stride_of(r) + 64) % 64 : (m_idx + stride_of(r)) % 64;
        na = lut_mag(m_idx);
        nb = lut_mag((m_idx + 16) % 64);
        m_adec = dec_of(na, m_amag, ds);
        m_bdec = dec_of(nb, m_bmag, ds);
        m_amag = na; m_bmag = nb;
        m_aneg = lut_neg(m_idx); m_bneg = lut_neg(m_idx + 16);
        check_all(req);
        chk({req, " R9 step_done high"}, int'(step_done), 1);
        @(negedge clk);
        chk({req, " R9 step_done low"}, int'(step_done), 0);
    endtask

    task automatic t_reset();
        model_home();
        repeat (3) @(negedge clk);
        check_all("R1 reset");
        chk("R9 reset step_done", int'(step_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after reset");
    endtask

    task automatic t_sixteenth_cw();
        for (int i = 0; i < 3; i++) do_step(1'b0, 3, 2, "R2 R3 R5 R6 sixteenth cw");
    endtask

    task automatic t_ignore();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            dir_in = i[0]; res_sel = 2'(i); decay_sel = 2'(i + 1);
            @(negedge clk);
            check_all("R4 no step");
            chk("R9 idle step_done", int'(step_done), 0);
        end
    endtask

    task automatic t_full_half();
        for (int i = 0; i < 4; i++) do_step(1'b0, 0, 1, "R2 R3 full cw wrap");
        for (int i = 0; i < 3; i++) do_step(1'b1, 1, 0, "R2 R3 half ccw wrap");
    endtask

    task automatic t_eighth_ccw();
        for (int i = 0; i < 2; i++) do_step(1'b1, 2, 3, "R2 R6 eighth ccw code3");
    endtask

    task automatic t_home_req();
        @(negedge clk);
        home_req = 1'b1;
        @(negedge clk);
        model_home();
        check_all("R1 home_req");
        for (int i = 0; i < 2; i++) begin
            dir_in = 1'b0; res_sel = 2'b00; step_in = 1'b1;
            @(negedge clk);
            step_in = 1'b0;
            @(negedge clk);
            check_all("R7 step during home");
            chk("R7 step_done during home", int'(step_done), 0);
        end
        home_req = 1'b0;
        repeat (2) @(negedge clk);
        check_all("R7 after home release");
    endtask

    task automatic t_full_circle();
        for (int i = 0; i < 64; i++) do_step(1'b0, 3, i % 4, "R5 R6 R8 circle");
    endtask

    task automatic t_async_reset();
        do_step(1'b0, 0, 2, "R2 before reset");
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        model_home();
        check_all("R1 async reset");
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_all("R1 after async reset");
        do_step(1'b1, 3, 1, "R3 ccw after reset");
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual 0 expected 1 (run completed)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_sixteenth_cw();
        t_ignore();
        t_full_half();
        t_eighth_ccw();
        t_home_req();
        t_full_circle();
        t_async_reset();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule